// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Selector

This block holds the replacement state of a 4-way set-associative cache and names the way to evict in any set. Each set owns three tree bits: a root bit that picks between the pair {way 0, way 1} and the pair {way 2, way 3}, a left bit that picks inside the first pair, and a right bit that picks inside the second pair. Ways 0, 1, 2 and 3 stand for the leaves A, B, C and D. Whenever the cache hits or fills a way, the owner pulses the update strobe with that set and way. The tree bits of that set are then pointed away from the way just touched.

A separate query port takes a set index and returns the victim way combinationally from the stored bits of that set. The tag array, data array and miss sequencing sit around this block and are not part of it. The set count is a parameter, 64 by default. Reset clears every set's bits, so way 0 is the first victim everywhere.

Top module: `plru4_repl`

## Requirements
- R1: After reset, every set holds root=0, left=0, right=0, and the victim reported for any set is way 0.
- R2: An update to way 0 (A) sets left=1 and root=1 in that set and leaves right unchanged.
- R3: An update to way 1 (B) sets left=0 and root=1 in that set and leaves right unchanged.
- R4: An update to way 2 (C) sets right=1 and root=0, and an update to way 3 (D) sets right=0 and root=0. Left is unchanged in both cases.
- R5: The victim is way 0 when root=0 and left=0, way 1 when root=0 and left=1, way 2 when root=1 and right=0, and way 3 when root=1 and right=1.
- R6: An update changes only the bits of the addressed set. The victim of every other set is unchanged.
- R7: With the update strobe low, no set's bits change, whatever the set and way inputs hold.
- R8: The victim output is combinational from stored state. When an update and a query address the same set in the same cycle, the query sees the bits from before that update, and the new bits are seen from the cycle after the clock edge.
- R9: Right after an update to a set, querying that set never returns the way just updated.
- R10: The lowest set (0) and the highest set (NUM_SETS-1) behave like every other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe for a hit or fill |
| upd_set | input | $clog2(NUM_SETS) | Set whose tree bits are updated |
| upd_way | input | 2 | Way that was hit or filled (0..3) |
| qry_set | input | $clog2(NUM_SETS) | Set whose victim is requested |
| victim_way | output | 2 | Way to evict in the queried set (0..3) |

## Verification
The hardest case to reach from the ports is one where the left and right sub-trees both hold values that no longer match the root's current direction. Each victim decode then depends on a bit written several updates earlier. Reaching it takes ordered update sequences on one set, for example A then C then B then D. These sequences walk the victim through all four ways, and an update that clobbers the wrong sub-tree bit shows up on the very next query. A long stretch of random updates and queries follows, biased to reuse the same set in the same cycle so that the pre-update read is exercised often. Set 0 and set 63 are also exercised, so that edge indices are covered.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [WAY_W-1:0] way_t;

  // root picks the pair, left picks within ways 0/1, right within ways 2/3
  typedef struct packed {
    logic right;
    logic left;
    logic root;
  } tree_t;
endpackage

// File: rtl/plru_tree_next.sv
module plru_tree_next
  import plru_pkg::*;
(
  input  tree_t cur,
  input  way_t  way,
  output tree_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (way)
      2'd0: begin nxt.left  = 1'b1; nxt.root = 1'b1; end
      2'd1: begin nxt.left  = 1'b0; nxt.root = 1'b1; end
      2'd2: begin nxt.right = 1'b1; nxt.root = 1'b0; end
      default: begin nxt.right = 1'b0; nxt.root = 1'b0; end
    endcase
  end
endmodule

// File: rtl/plru_tree_pick.sv
module plru_tree_pick
  import plru_pkg::*;
(
  input  tree_t cur,
  output way_t  victim
);
  always_comb begin
    if (!cur.root) victim = cur.left  ? 2'd1 : 2'd0;
    else           victim = cur.right ? 2'd3 : 2'd2;
  end
endmodule

// File: rtl/plru_tree_store.sv
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_t            wr_data,
  input  logic [SET_W-1:0] rd_a_set,
  output tree_t            rd_a_data,
  input  logic [SET_W-1:0] rd_b_set,
  output tree_t            rd_b_data
);
  tree_t arr [NUM_SETS];
  logic  rst_d;
  logic  armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) arr[s] <= '0;
    end else if (wr_en) begin
      arr[wr_set] <= wr_data;
    end
  end

  assign rd_a_data = arr[rd_a_set];
  assign rd_b_data = arr[rd_b_set];

  always_ff @(posedge clk) begin
    rst_d <= rst;
    armed <= !rst;
  end

  // R1: the first edge out of reset sees cleared sets at both ends
  always_ff @(posedge clk) begin
    if (!rst && rst_d) begin
      a_r1_reset_clear: assert (arr[0] == '0 && arr[NUM_SETS-1] == '0)
        else $error("a_r1_reset_clear");
    end
  end

  // R6: a write to another set leaves set 0 alone
  a_r6_other_sets_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en && wr_set != '0) |=> $stable(arr[0]));

  // R7: no write strobe, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !wr_en) |=> $stable(arr[NUM_SETS-1]));
endmodule

// File: rtl/plru4_repl.sv
module plru4_repl
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [1:0]       upd_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [1:0]       victim_way
);
  tree_t upd_cur, upd_nxt, qry_cur;
  way_t  pick;
  logic  armed;

  plru_tree_store #(.NUM_SETS(NUM_SETS)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(upd_en), .wr_set(upd_set), .wr_data(upd_nxt),
    .rd_a_set(upd_set), .rd_a_data(upd_cur),
    .rd_b_set(qry_set), .rd_b_data(qry_cur)
  );

  plru_tree_next u_next (.cur(upd_cur), .way(upd_way), .nxt(upd_nxt));
  plru_tree_pick u_pick (.cur(qry_cur), .victim(pick));

  assign victim_way = pick;

  always_ff @(posedge clk) armed <= !rst;

  // R2: after a way-0 update the same set points at the right pair
  a_r2_after_a: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(upd_en) && $past(upd_way) == 2'd0 && qry_set == $past(upd_set))
      |-> victim_way[1]);

  // R3: after a way-1 update the same set points at the right pair
  a_r3_after_b: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(upd_en) && $past(upd_way) == 2'd1 && qry_set == $past(upd_set))
      |-> victim_way[1]);

  // R4: after a way-2/3 update the same set points at the left pair
  a_r4_after_cd: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(upd_en) && $past(upd_way[1]) && qry_set == $past(upd_set))
      |-> !victim_way[1]);

  // R9: the way just touched is never the next victim of its set
  a_r9_not_recent: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(upd_en) && qry_set == $past(upd_set))
      |-> victim_way != $past(upd_way));
endmodule

// File: tb/tb_plru4_repl.sv
module tb_plru4_repl;
  localparam int NS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_en = 1'b0;
  logic [5:0] upd_set = '0;
  logic [1:0] upd_way = '0;
  logic [5:0] qry_set = '0;
  logic [1:0] victim_way;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model: one integer per tree bit per set
  int m_root [NS];
  int m_left [NS];
  int m_right[NS];

  always #5 clk = ~clk;

  plru4_repl #(.NUM_SETS(NS)) dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_set(upd_set),
    .upd_way(upd_way), .qry_set(qry_set), .victim_way(victim_way)
  );

  function automatic int mvict(int s);
    if (m_root[s] == 0) return (m_left[s] != 0) ? 1 : 0;
    return (m_right[s] != 0) ? 3 : 2;
  endfunction

  function automatic void mupd(int s, int w);
    case (w)
      0: begin m_left[s] = 1;  m_root[s] = 1; end
      1: begin m_left[s] = 0;  m_root[s] = 1; end
      2: begin m_right[s] = 1; m_root[s] = 0; end
      default: begin m_right[s] = 0; m_root[s] = 0; end
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare against model (pre-edge state), then clock
  task automatic step(string tag, bit en, int s, int w, int q);
    @(negedge clk);
    upd_en = en; upd_set = s[5:0]; upd_way = w[1:0]; qry_set = q[5:0];
    #1;
    check(tag, int'(victim_way), mvict(q));
    @(posedge clk);
    if (en) mupd(s, w);
  endtask

  // query only, against a fixed expected way worked out by hand
  task automatic fixed(string tag, int q, int exp);
    @(negedge clk);
    upd_en = 1'b0; qry_set = q[5:0];
    #1;
    check(tag, int'(victim_way), exp);
    check(tag, int'(victim_way), mvict(q));
    @(posedge clk);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_root[s] = 0; m_left[s] = 0; m_right[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: all sets start with way 0 as victim
    for (int s = 0; s < NS; s++) fixed("R1", s, 0);

    // R2/R3/R4/R5: walk set 7 through all four victims
    step("R2", 1, 7, 0, 7);
    fixed("R2", 7, 2);
    step("R4", 1, 7, 2, 7);
    fixed("R4", 7, 1);
    step("R3", 1, 7, 1, 7);
    fixed("R5", 7, 3);
    step("R4", 1, 7, 3, 7);
    fixed("R5", 7, 0);

    // R7: strobe low, set/way inputs wiggle, set 7 must keep victim 0
    step("R7", 0, 7, 0, 7);
    step("R7", 0, 7, 2, 7);
    fixed("R7", 7, 0);

    // R6: heavy traffic on set 9 leaves 8 and 10 at their reset victim
    step("R6", 1, 9, 0, 8);
    step("R6", 1, 9, 3, 10);
    step("R6", 1, 9, 1, 8);
    fixed("R6", 8, 0);
    fixed("R6", 10, 0);
    fixed("R6", 9, 2);

    // R8: same-cycle update and query sees the old bits (victim 0)
    step("R8", 1, 12, 1, 12);
    fixed("R8", 12, 2);

    // R9 + R10: edge sets
    step("R10", 1, 0, 2, 0);
    fixed("R10", 0, 0);
    step("R9", 1, 63, 3, 63);
    fixed("R10", 63, 0);
    step("R10", 1, 63, 0, 63);
    fixed("R9", 63, 2);

    // R9: random mix, often querying the set just updated
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(7, 0) * 9;
      int w = $urandom_range(3, 0);
      int q = ($urandom_range(1, 0) != 0) ? s : $urandom_range(63, 0);
      step("R9", bit'($urandom_range(3, 0) != 0), s, w, q);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule